// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block places the processor core into one of two sleep modes and brings it back out. Software writes a two-bit mode request. A light sleep stops only the core clock while the peripheral clocks keep running. A deep sleep also stops the peripheral clocks and removes the oscillator enable. The request is written by the last instruction executed before sleep, and the storage keeps its contents because the block never touches it.

Light sleep ends on any interrupt that is both pending and enabled, or on the hardware reset input. When the reset input ends light sleep, the core is allowed to run on for a fixed grace window of two machine cycles before the internal reset takes over. For that window a RAM-write-inhibit output is raised, while port writes stay allowed. Deep sleep ignores interrupts. Only the reset input wakes it, and the oscillator enable comes back before the internal reset is released.

The sequencer runs on an always-on clock that is not gated by its own outputs. Every output is decoded from registered state, so each output responds one clock after the input that caused the change is sampled.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, the block is running: core, peripheral and oscillator enables are 1, inhibit is 0, internal reset is 0, and the mode readback is 00.
- R2: While running, a request write with bit 0 set and bit 1 clear enters light sleep on the next cycle. In light sleep the core enable is 0, the peripheral and oscillator enables stay 1, and the readback shows 01.
- R3: While running, a request write with bit 1 set enters deep sleep on the next cycle, whatever bit 0 holds, so deep sleep has priority. In deep sleep all three enables are 0 and the readback shows the written value.
- R4: In light sleep, an interrupt line that is both pending and enabled, with reset low, restores the core enable on the next cycle. A line that is pending but not enabled has no effect.
- R5: In deep sleep, interrupts have no effect. The enables stay 0 until the reset input is seen.
- R6: The reset input sampled high in light sleep restores the core enable on the next cycle and raises inhibit for exactly MC_LEN*WIN_MC cycles (12 with the default parameters). Internal reset stays 0 during those cycles and goes to 1 in the cycle that follows them.
- R7: Internal reset stays 1 while the reset input is high, and for at least one cycle. It drops on the cycle after the reset input is sampled low. A reset seen while running asserts internal reset on the next cycle, with no inhibit.
- R8: The reset input sampled high in deep sleep turns all enables back on and asserts internal reset on the next cycle. The oscillator enable is therefore high before internal reset is released.
- R9: The mode readback returns to 00 on any exit from sleep. Request writes made while not running (inside the grace window or during internal reset) are ignored.
- R10: In light sleep, when the reset input and an enabled interrupt arrive together, the reset takes priority and opens the grace window.
- R11: A request write of 00 while running leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hw_rst | input | 1 | Synchronised hardware reset request, active high |
| pcon_wr | input | 1 | Write strobe for the mode request |
| pcon_wdata | input | 2 | Request: bit 0 selects light sleep, bit 1 selects deep sleep |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| mode_req | output | 2 | Readback of the stored request bits |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes during the grace window |
| int_rst | output | 1 | Internal reset to the core |

## Verification
Every result is due exactly one clock after the rising edge that samples its cause. The exceptions are the end of the grace window, which is due MC_LEN*WIN_MC cycles after entry, and the release of internal reset, which is due one cycle after the reset input is seen low. The bench updates its behavioural model at each rising edge and compares all outputs at the following falling edge, so each comparison lands in the first cycle where the new value must be visible. Directed checks wait the same single cycle after each stimulus. The grace window is measured by counting the falling edges on which inhibit is high.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PDOWN = 3'd2,
    ST_WIN   = 3'd3,
    ST_RST   = 3'd4
  } lp_state_e;

  typedef struct packed {
    logic pd;
    logic idl;
  } mode_req_t;
endpackage

// File: rtl/lpc_mode_reg.sv
module lpc_mode_reg
  import lpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  mode_req_t wdata,
  input  logic      clr,
  output mode_req_t q
);
  mode_req_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (clr)        q_nxt = '0;
    else if (wr_en) q_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/lpc_win_timer.sv
module lpc_win_timer #(
  parameter int WIN_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (load)            cnt_nxt = LOAD_VAL;
    else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/lpc_fsm.sv
module lpc_fsm
  import lpc_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst,
  input  logic             pcon_wr,
  input  mode_req_t        req,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             win_done,
  output lp_state_e        st,
  output logic             win_load,
  output logic             mode_wr,
  output logic             mode_clr
);
  lp_state_e st_nxt;
  logic [N_IRQ-1:0] live;
  logic wake;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_mask
    assign live[i] = irq_pend[i] & irq_en[i];
  end
  assign wake = |live;

  always_comb begin
    st_nxt   = st;
    win_load = 1'b0;
    mode_wr  = 1'b0;
    mode_clr = 1'b0;
    case (st)
      ST_RUN: begin
        if (hw_rst) st_nxt = ST_RST;
        else if (pcon_wr) begin
          mode_wr = 1'b1;
          if (req.pd)       st_nxt = ST_PDOWN;
          else if (req.idl) st_nxt = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (hw_rst) begin
          st_nxt   = ST_WIN;
          win_load = 1'b1;
          mode_clr = 1'b1;
        end else if (wake) begin
          st_nxt   = ST_RUN;
          mode_clr = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (hw_rst) begin
          st_nxt   = ST_RST;
          mode_clr = 1'b1;
        end
      end
      ST_WIN: begin
        if (win_done) st_nxt = ST_RST;
      end
      ST_RST: begin
        if (!hw_rst) st_nxt = ST_RUN;
      end
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RUN;
    else        st <= st_nxt;
  end

  // R6: the window hands over to internal reset when the timer expires
  p_win_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && win_done) |=> (st == ST_RST));

  // R6: the window is held while the timer still runs
  p_win_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && !win_done) |=> (st == ST_WIN));
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lpc_pkg::*;
#(
  parameter int MC_LEN = 6,
  parameter int WIN_MC = 2,
  parameter int N_IRQ  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst,
  input  logic             pcon_wr,
  input  logic [1:0]       pcon_wdata,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  output logic [1:0]       mode_req,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             ram_wr_inhibit,
  output logic             int_rst
);
  localparam int WIN_CYC = MC_LEN * WIN_MC;

  lp_state_e st;
  logic      win_load, win_done, mode_wr, mode_clr;
  mode_req_t req_w, req_q;

  assign req_w = mode_req_t'(pcon_wdata);

  lpc_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .pcon_wr(pcon_wr),
    .req(req_w), .irq_pend(irq_pend), .irq_en(irq_en),
    .win_done(win_done), .st(st), .win_load(win_load),
    .mode_wr(mode_wr), .mode_clr(mode_clr)
  );

  lpc_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load), .done(win_done)
  );

  lpc_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_wr), .wdata(req_w),
    .clr(mode_clr), .q(req_q)
  );

  assign mode_req = req_q;

  always_comb begin
    cpu_clk_en     = 1'b1;
    per_clk_en     = 1'b1;
    osc_en         = 1'b1;
    ram_wr_inhibit = 1'b0;
    int_rst        = 1'b0;
    case (st)
      ST_IDLE:  cpu_clk_en = 1'b0;
      ST_PDOWN: begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        osc_en     = 1'b0;
      end
      ST_WIN:   ram_wr_inhibit = 1'b1;
      ST_RST:   int_rst = 1'b1;
      default:  ;
    endcase
  end

  // checks across the ports
  logic running, wake_any;
  assign running  = cpu_clk_en && !ram_wr_inhibit && !int_rst;
  assign wake_any = |(irq_pend & irq_en);

  p_idle_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pcon_wr && pcon_wdata == 2'b01 && !hw_rst)
      |=> (!cpu_clk_en && per_clk_en && osc_en));

  p_pd_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pcon_wr && pcon_wdata[1] && !hw_rst)
      |=> (!osc_en && !cpu_clk_en && !per_clk_en));

  p_irq_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && wake_any && !hw_rst)
      |=> (cpu_clk_en && !ram_wr_inhibit && !int_rst));

  p_pd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !hw_rst) |=> !osc_en);

  p_idle_rst_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && hw_rst)
      |=> (ram_wr_inhibit && cpu_clk_en && !int_rst));

  p_rst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rst && hw_rst) |=> int_rst);

  p_pd_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && hw_rst) |=> (osc_en && int_rst));

  p_bits_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> (mode_req == 2'b00));
endmodule

// File: tb/tb_lp_mode_ctrl.sv
`timescale 1ns/1ps
module tb_lp_mode_ctrl;
  localparam int MC_LEN  = 6;
  localparam int WIN_MC  = 2;
  localparam int N_IRQ   = 4;
  localparam int WIN_CYC = MC_LEN * WIN_MC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_rst = 1'b0;
  logic pcon_wr = 1'b0;
  logic [1:0] pcon_wdata = 2'b00;
  logic [N_IRQ-1:0] irq_pend = '0;
  logic [N_IRQ-1:0] irq_en = '0;
  logic [1:0] mode_req;
  logic cpu_clk_en, per_clk_en, osc_en, ram_wr_inhibit, int_rst;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  lp_mode_ctrl #(.MC_LEN(MC_LEN), .WIN_MC(WIN_MC), .N_IRQ(N_IRQ)) dut (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .pcon_wr(pcon_wr),
    .pcon_wdata(pcon_wdata), .irq_pend(irq_pend), .irq_en(irq_en),
    .mode_req(mode_req), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .ram_wr_inhibit(ram_wr_inhibit), .int_rst(int_rst)
  );

  // behavioural model: 0 run, 1 light sleep, 2 deep sleep, 3 grace, 4 reset
  int m_st = 0;
  int m_win = 0;
  logic [1:0] m_bits = 2'b00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_win = 0; m_bits = 2'b00;
    end else begin
      case (m_st)
        0: if (hw_rst) m_st = 4;
           else if (pcon_wr) begin
             m_bits = pcon_wdata;
             if (pcon_wdata[1]) m_st = 2;
             else if (pcon_wdata[0]) m_st = 1;
           end
        1: if (hw_rst) begin m_st = 3; m_win = WIN_CYC; m_bits = 2'b00; end
           else if ((irq_pend & irq_en) != '0) begin m_st = 0; m_bits = 2'b00; end
        2: if (hw_rst) begin m_st = 4; m_bits = 2'b00; end
        3: if (m_win == 1) m_st = 4; else m_win = m_win - 1;
        default: if (!hw_rst) m_st = 0;
      endcase
    end
  end

  function automatic logic [4:0] exp_vec(int s);
    case (s)
      1: return 5'b01100;
      2: return 5'b00000;
      3: return 5'b11110;
      4: return 5'b11101;
      default: return 5'b11100;
    endcase
  endfunction

  function automatic logic [4:0] act_vec();
    return {cpu_clk_en, per_clk_en, osc_en, ram_wr_inhibit, int_rst};
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished)
      check({cur_req, " model"}, {act_vec(), mode_req}, {exp_vec(m_st), m_bits});
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] v);
    pcon_wdata = v; pcon_wr = 1'b1;
    step(1);
    pcon_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    step(3);
    rst_n = 1'b1;
    step(1);
    cur_req = "R1";
    check("R1", {act_vec(), mode_req}, {5'b11100, 2'b00});

    cur_req = "R11";
    wr(2'b00);
    check("R11", {act_vec(), mode_req}, {5'b11100, 2'b00});

    cur_req = "R2";
    wr(2'b01);
    check("R2", {act_vec(), mode_req}, {5'b01100, 2'b01});
    cur_req = "R4";
    irq_pend = 4'b0100; irq_en = 4'b1011;
    step(3);
    check("R4 masked", {act_vec(), mode_req}, {5'b01100, 2'b01});
    irq_en = 4'b0100;
    step(1);
    check("R4 wake", {act_vec(), mode_req}, {5'b11100, 2'b00});
    irq_pend = '0; irq_en = '0;
    step(1);

    cur_req = "R3";
    wr(2'b11);
    check("R3", {act_vec(), mode_req}, {5'b00000, 2'b11});
    cur_req = "R5";
    irq_pend = 4'b1111; irq_en = 4'b1111;
    step(5);
    check("R5", {act_vec(), mode_req}, {5'b00000, 2'b11});
    irq_pend = '0; irq_en = '0;
    cur_req = "R8";
    hw_rst = 1'b1;
    step(1);
    check("R8 wake", {act_vec(), mode_req}, {5'b11101, 2'b00});
    step(2);
    check("R8 hold", {act_vec(), mode_req}, {5'b11101, 2'b00});
    hw_rst = 1'b0;
    step(1);
    check("R8 release", {act_vec(), mode_req}, {5'b11100, 2'b00});

    cur_req = "R10";
    wr(2'b01);
    hw_rst = 1'b1; irq_pend = 4'b0001; irq_en = 4'b0001;
    step(1);
    check("R10", {act_vec(), mode_req}, {5'b11110, 2'b00});
    hw_rst = 1'b0; irq_pend = '0; irq_en = '0;
    cur_req = "R6";
    cnt = 0;
    while (ram_wr_inhibit && cnt < 100) begin
      cnt++;
      if (cnt == 2) begin pcon_wdata = 2'b01; pcon_wr = 1'b1; end
      step(1);
      pcon_wr = 1'b0;
      if (cnt == 2) check("R9 write ignored", {act_vec(), mode_req}, {5'b11110, 2'b00});
    end
    check("R6 window length", 7'(cnt), 7'(WIN_CYC));
    check("R6 handover", {act_vec(), mode_req}, {5'b11101, 2'b00});
    cur_req = "R7";
    step(1);
    check("R7 short reset", {act_vec(), mode_req}, {5'b11100, 2'b00});

    hw_rst = 1'b1;
    step(1);
    check("R7 run reset", {act_vec(), mode_req}, {5'b11101, 2'b00});
    pcon_wdata = 2'b10; pcon_wr = 1'b1;
    step(1);
    pcon_wr = 1'b0;
    check("R9 write in reset", {act_vec(), mode_req}, {5'b11101, 2'b00});
    step(2);
    hw_rst = 1'b0;
    step(1);
    check("R7 release", {act_vec(), mode_req}, {5'b11100, 2'b00});

    cur_req = "R6";
    wr(2'b01);
    hw_rst = 1'b1;
    step(WIN_CYC);
    check("R6 long window end", {act_vec(), mode_req}, {5'b11110, 2'b00});
    step(1);
    check("R6 reset after window", {act_vec(), mode_req}, {5'b11101, 2'b00});
    step(3);
    check("R7 held", {act_vec(), mode_req}, {5'b11101, 2'b00});
    hw_rst = 1'b0;
    step(2);
    check("R7 final", {act_vec(), mode_req}, {5'b11100, 2'b00});

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule